// File: doc/BRIEF.md
# Prioritized Chip-Select Address Decoder

This block turns each access on a 24-bit bank-linear address bus into exactly one target select: one of eight active-low external chip selects, or a select for on-chip RAM. Several address windows overlap. The block settles every overlap with a fixed precedence, so an access never reaches two devices. Two control registers shape the decode:

- A bus control register gates the upper half of bank 00 between the ROM window select and the large RAM select.
- A speed control register enables or disables the low on-chip RAM. It also holds the speed bits.

Each access also carries a two-bit speed class. A downstream bus sequencer uses it to stretch the cycle. The class is fast clock, fast clock divided by four, or the slow low-frequency clock. The clock divider and the memories are outside the block.

An access enters as an address qualified by `addr_valid`. The decoded result leaves exactly one cycle later, qualified by `sel_valid`. There is no ready signal and no back-pressure. The decoder accepts one address on every cycle, including back-to-back cycles. The consumer must take each result in the cycle it is presented. The register write port is a plain strobe.

Top module: `chip_select_decoder`

## Requirements
- R1: `sel_valid` equals `addr_valid` delayed by one clock. While `sel_valid` is low, `cs_n` is 8'hFF, `iram_sel` is 0 and `spd` is 2'b00. Back-to-back valid cycles each yield a result.
- R2: Every valid result asserts exactly one of the nine selects (`cs_n[0..7]` low, or `iram_sel` high).
- R3: Bank byte (addr[23:16]) 00–3F selects `cs_n[5]`, 40–BF selects `cs_n[6]`, and C0–FF selects `cs_n[7]`, unless a higher-precedence rule applies.
- R4: In bank 00, offsets 0000–7FFF select `cs_n[3]` instead of `cs_n[5]`, unless a higher-precedence rule applies.
- R5: In bank 00, offsets 0000–01FF select `iram_sel` when speed control bit 2 is 0. When bit 2 is 1 they fall through to `cs_n[3]`.
- R6: In bank 00, offsets 8000–FFFF select `cs_n[4]` when bus control bit 7 is 1. When bit 7 is 0 they fall through to `cs_n[5]`.
- R7: Bank 00 offsets DF00–DF1F select `cs_n[0]`, DFC0–DFFF select `cs_n[1]`, and the rest of page DF outside DF80–DFBF selects `cs_n[2]`. These override R6 and R3.
- R8: Bank 00 offsets DF80–DFBF always select `iram_sel`, whatever speed control bit 2 holds.
- R9: Speed class encoding is 2'b00 fast, 2'b01 fast/4, 2'b10 slow. Targets `cs_n[4]`, `cs_n[5]`, `cs_n[6]` and `cs_n[7]` take speed control bits 4, 5, 6 and 7 respectively (0 fast, 1 fast/4). All other targets take bit 3.
- R10: Speed control bit 1 set forces the speed class to 2'b10 for every target.
- R11: `reg_wr` with `reg_sel`=0 loads the bus control register and with `reg_sel`=1 loads the speed control register. Reset values are 8'h80 and 8'h02. A write at one clock edge governs accesses presented from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 24 | Access address, bank in bits 23:16 |
| addr_valid | input | 1 | Qualifies `addr` for one decode |
| reg_wr | input | 1 | Control register write strobe |
| reg_sel | input | 1 | 0 bus control, 1 speed control |
| reg_wdata | input | 8 | Control register write data |
| sel_valid | output | 1 | Result valid, one cycle after `addr_valid` |
| cs_n | output | 8 | Active-low external chip selects |
| iram_sel | output | 1 | On-chip RAM select |
| spd | output | 2 | Speed class of the access |

## Verification
The assertions assume that `addr` is meaningful only in cycles where `addr_valid` is high. They also assume that reset is held long enough for the registered outputs to settle at their idle values. Beyond that, they accept any address and any register contents.

The stimulus changes inputs only on the falling clock edge. It never issues a register write in the same cycle as an access whose expected value depends on that write. This keeps each expected result tied to a single, known register state. Accesses are sometimes held back to back, and sometimes separated by idle cycles, so that the idle output state is also observed.

// File: rtl/csd_pkg.sv
package csd_pkg;
  localparam int NUM_CS   = 8;
  localparam int TGT_W    = 4;
  localparam int IRAM_TGT = NUM_CS;

  typedef enum logic [1:0] {
    SPD_FAST = 2'b00,
    SPD_QTR  = 2'b01,
    SPD_SLOW = 2'b10
  } spd_e;

  // speed control register bit positions
  localparam int SC_SLOW_ALL = 1;
  localparam int SC_IRAM_OFF = 2;
  localparam int SC_COMMON   = 3;
  localparam int SC_REGION0  = 4;  // bits 4..7 -> cs 4..7
  // bus control register bit positions
  localparam int BC_ROM_EN   = 7;

  localparam logic [7:0] BUS_RST = 8'h80;
  localparam logic [7:0] SPD_RST = 8'h02;
endpackage

// File: rtl/csd_ctrl_regs.sv
module csd_ctrl_regs
  import csd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              sel,
  input  logic [DATA_W-1:0] wdata,
  output logic              rom_en,
  output logic              iram_en,
  output logic              slow_all,
  output logic              common_qtr,
  output logic [3:0]        region_qtr
);
  logic [DATA_W-1:0] bus_q, spd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q <= DATA_W'(BUS_RST);
      spd_q <= DATA_W'(SPD_RST);
    end else if (wr) begin
      if (sel) spd_q <= wdata;
      else     bus_q <= wdata;
    end
  end

  assign rom_en     = bus_q[BC_ROM_EN];
  assign iram_en    = ~spd_q[SC_IRAM_OFF];
  assign slow_all   = spd_q[SC_SLOW_ALL];
  assign common_qtr = spd_q[SC_COMMON];
  assign region_qtr = spd_q[SC_REGION0 +: 4];
endmodule

// File: rtl/csd_region_match.sv
module csd_region_match
  import csd_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              iram_en,
  input  logic              rom_en,
  output logic [TGT_W-1:0]  tgt
);
  localparam int BANK_LO = ADDR_W - 8;

  logic [7:0]  bank;
  logic [15:0] off;
  logic        bank0;

  assign bank  = addr[ADDR_W-1:BANK_LO];
  assign off   = addr[15:0];
  assign bank0 = (bank == 8'h00);

  // fixed precedence, highest first
  always_comb begin
    if      (bank0 && off[15:6] == 10'h37E)       tgt = TGT_W'(IRAM_TGT); // DF80-DFBF
    else if (bank0 && off[15:5] == 11'h6F8)       tgt = TGT_W'(0);        // DF00-DF1F
    else if (bank0 && off[15:6] == 10'h37F)       tgt = TGT_W'(1);        // DFC0-DFFF
    else if (bank0 && off[15:8] == 8'hDF)         tgt = TGT_W'(2);        // rest of page DF
    else if (bank0 && off[15:9] == 7'd0 && iram_en) tgt = TGT_W'(IRAM_TGT);
    else if (bank0 && !off[15])                   tgt = TGT_W'(3);
    else if (bank0 && rom_en)                     tgt = TGT_W'(4);
    else if (bank < 8'h40)                        tgt = TGT_W'(5);
    else if (bank < 8'hC0)                        tgt = TGT_W'(6);
    else                                          tgt = TGT_W'(7);
  end
endmodule

// File: rtl/csd_speed_lookup.sv
module csd_speed_lookup
  import csd_pkg::*;
(
  input  logic [TGT_W-1:0] tgt,
  input  logic             slow_all,
  input  logic             common_qtr,
  input  logic [3:0]       region_qtr,
  output spd_e             spd
);
  logic qtr;

  always_comb begin
    case (tgt)
      TGT_W'(4): qtr = region_qtr[0];
      TGT_W'(5): qtr = region_qtr[1];
      TGT_W'(6): qtr = region_qtr[2];
      TGT_W'(7): qtr = region_qtr[3];
      default:   qtr = common_qtr;
    endcase
    if (slow_all) spd = SPD_SLOW;
    else          spd = qtr ? SPD_QTR : SPD_FAST;
  end
endmodule

// File: rtl/chip_select_decoder.sv
module chip_select_decoder
  import csd_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              addr_valid,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              sel_valid,
  output logic [NUM_CS-1:0] cs_n,
  output logic              iram_sel,
  output logic [1:0]        spd
);
  logic             rom_en, iram_en, slow_all, common_qtr;
  logic [3:0]       region_qtr;
  logic [TGT_W-1:0] tgt;
  spd_e             spd_d;
  logic [NUM_CS-1:0] cs_d;

  csd_ctrl_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .rom_en(rom_en), .iram_en(iram_en), .slow_all(slow_all),
    .common_qtr(common_qtr), .region_qtr(region_qtr)
  );

  csd_region_match #(.ADDR_W(ADDR_W)) u_match (
    .addr(addr), .iram_en(iram_en), .rom_en(rom_en), .tgt(tgt)
  );

  csd_speed_lookup u_speed (
    .tgt(tgt), .slow_all(slow_all), .common_qtr(common_qtr),
    .region_qtr(region_qtr), .spd(spd_d)
  );

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_d[g] = addr_valid && (tgt == TGT_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_valid <= 1'b0;
      cs_n      <= '1;
      iram_sel  <= 1'b0;
      spd       <= SPD_FAST;
    end else begin
      sel_valid <= addr_valid;
      cs_n      <= ~cs_d;
      iram_sel  <= addr_valid && (tgt == TGT_W'(IRAM_TGT));
      spd       <= addr_valid ? spd_d : SPD_FAST;
    end
  end

  // ---------------- assertions ----------------
  p_valid_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> sel_valid == $past(addr_valid && rst_n));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |-> (cs_n == '1 && !iram_sel && spd == SPD_FAST));

  p_one_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> $countones({~cs_n, iram_sel}) == 1);

  p_io_ram_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && addr[ADDR_W-1:6] == (ADDR_W-6)'(24'h00DF80 >> 6)) |=> iram_sel);

  p_rom_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !rom_en && addr[ADDR_W-1:15] == '0 + (ADDR_W-15)'(1)) |=> cs_n[4]);

  p_force_slow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && $past(slow_all)) |-> spd == SPD_SLOW);
endmodule

// File: tb/tb_chip_select_decoder.sv
module tb_chip_select_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] addr = '0;
  logic        addr_valid = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic        sel_valid;
  logic [7:0]  cs_n;
  logic        iram_sel;
  logic [1:0]  spd;

  always #10 clk = ~clk; // 50 MHz

  chip_select_decoder dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .addr_valid(addr_valid),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .sel_valid(sel_valid), .cs_n(cs_n), .iram_sel(iram_sel), .spd(spd)
  );

  typedef struct {
    int        tgt;   // 0..7 external, 8 on-chip RAM
    logic [1:0] spd;
    string     req;
    logic [23:0] a;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic acc(input logic [23:0] a, input int t, input logic [1:0] s,
                     input string req);
    exp_t e;
    @(negedge clk);
    addr = a; addr_valid = 1'b1;
    e.tgt = t; e.spd = s; e.req = req; e.a = a;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      addr_valid = 1'b0;
    end
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    @(negedge clk);
    addr_valid = 1'b0;
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && sel_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R1", "unexpected result", 32'(sel_valid), 32'd0);
        end else begin
          exp_t e;
          logic [7:0] ecs;
          e = exp_q.pop_front();
          ecs = (e.tgt < 8) ? ~(8'd1 << e.tgt) : 8'hFF;
          check(cs_n == ecs && iram_sel == (e.tgt == 8), e.req,
                $sformatf("select @%h", e.a), {23'd0, iram_sel, cs_n},
                {23'd0, (e.tgt == 8), ecs});
          check(spd == e.spd, e.req, $sformatf("speed @%h", e.a),
                32'(spd), 32'(e.spd));
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #2;
    // R1 reset/idle state
    check(!sel_valid && cs_n == 8'hFF && !iram_sel && spd == 2'b00, "R1",
          "reset idle", {21'd0, sel_valid, iram_sel, spd, cs_n}, 32'h0FF);

    // R11 reset values: ROM on, IRAM on, everything slow
    acc(24'h000100, 8, 2'b10, "R5");
    acc(24'h000200, 3, 2'b10, "R4");
    acc(24'h009000, 4, 2'b10, "R6");
    acc(24'h123456, 5, 2'b10, "R3");
    acc(24'h3FFFFF, 5, 2'b10, "R3");
    acc(24'h400000, 6, 2'b10, "R3");
    acc(24'hBFFFFF, 6, 2'b10, "R3");
    acc(24'hC00000, 7, 2'b10, "R3");
    acc(24'hFFFFFF, 7, 2'b10, "R3");
    acc(24'h00DF00, 0, 2'b10, "R7");
    acc(24'h00DF1F, 0, 2'b10, "R7");
    acc(24'h00DF20, 2, 2'b10, "R7");
    acc(24'h00DF7F, 2, 2'b10, "R7");
    acc(24'h00DF80, 8, 2'b10, "R8");
    acc(24'h00DFBF, 8, 2'b10, "R8");
    acc(24'h00DFC0, 1, 2'b10, "R7");
    acc(24'h00DFFF, 1, 2'b10, "R7");
    idle(2);
    @(posedge clk); #2;
    check(!sel_valid && cs_n == 8'hFF, "R1", "idle after burst",
          {23'd0, sel_valid, cs_n}, 32'h0FF);

    // speed: cs5,cs7 fast/4, others fast (R9, R11)
    wr(1'b1, 8'hA0);
    acc(24'h009000, 4, 2'b00, "R9");
    acc(24'h200000, 5, 2'b01, "R9");
    acc(24'h500000, 6, 2'b00, "R9");
    acc(24'hD00000, 7, 2'b01, "R9");
    acc(24'h000100, 8, 2'b00, "R9");
    acc(24'h00DF00, 0, 2'b00, "R9");
    idle(1);

    // IRAM disabled, common fast/4, cs4/cs6 fast/4
    wr(1'b1, 8'h5C);
    acc(24'h000100, 3, 2'b01, "R5");
    acc(24'h0001FF, 3, 2'b01, "R5");
    acc(24'h00DF90, 8, 2'b01, "R8");
    acc(24'h009000, 4, 2'b01, "R9");
    acc(24'h300000, 5, 2'b00, "R9");
    idle(1);

    // ROM window off (R6, R11)
    wr(1'b0, 8'h00);
    acc(24'h009000, 5, 2'b00, "R6");
    acc(24'h008000, 5, 2'b00, "R6");
    acc(24'h00DF05, 0, 2'b01, "R7");
    acc(24'h00DFE0, 1, 2'b01, "R7");
    idle(1);

    // global slow (R10)
    wr(1'b1, 8'hFF);
    acc(24'h700000, 6, 2'b10, "R10");
    acc(24'h00DF85, 8, 2'b10, "R10");
    acc(24'h000000, 3, 2'b10, "R10");
    idle(3);

    check(exp_q.size() == 0, "R1", "results outstanding",
          32'(exp_q.size()), 32'd0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule